// File: doc/BRIEF.md
# Setup-Frame Perfect Address Filter

This block decides, for each received frame, whether its 48-bit destination address belongs to the station. It keeps a table of 16 exact addresses. Software fills the table by sending a 192-byte setup frame through the same byte stream that carries ordinary frames. Ordinary frames then run through a compare against all 16 entries. The block gives a one-cycle accept/reject verdict straight after the sixth destination byte. Two inputs widen acceptance: one passes the all-ones broadcast address, the other (promiscuous) passes everything.

Bytes arrive with a valid strobe, and the first byte of every frame is marked. With that first byte the block samples a setup flag and an 11-bit length, both taken from the transmit control word. The setup frame is built from 16 slices of 12 bytes. Each address half-word appears twice in every four bytes, and only the first copy is written into the table.

The controller is a four-state machine. ST_IDLE is entered after reset and after a frame has been fully handled. ST_LOAD parses setup bytes. ST_DEST gathers destination bytes. ST_SKIP ignores a frame that carries the setup flag with a wrong length. The transitions are named here:
- A frame start always overrides the current state. It goes to ST_LOAD when the frame is a valid setup frame, to ST_SKIP when it has the setup flag with another length, and to ST_DEST otherwise.
- ST_LOAD goes to ST_IDLE on the 192nd byte.
- ST_DEST goes to ST_IDLE on the sixth destination byte.
- ST_IDLE and ST_SKIP stay where they are until the next frame start.

Top module: `dst_perfect_filter`

## Requirements
- R1: After reset, every table entry is zero and the table counts as unloaded. verdict_vld, accept and load_done are low. An all-zero destination is rejected while the table is unloaded.
- R2: A frame is a setup frame only when desc_setup (bit 27 of the control word) is high and desc_len (control word bits 10:0) equals 192, both sampled with the first byte. If desc_setup is high with any other length, the frame is ignored: the table, the loaded state and load_done are unchanged, and no verdict is given.
- R3: Setup byte k belongs to entry k/12 at position p = k mod 12. Positions 0,1,4,5,8,9 supply address bytes 0,1,2,3,4,5 of that entry. Positions 2,3,6,7,10,11 are duplicates and are ignored. Address byte 0 is the first destination byte on the wire.
- R4: verdict_vld is high for exactly one cycle, right after the clock edge that samples the sixth destination byte. accept is low whenever verdict_vld is low.
- R5: With promisc and accept_bcast low and the table loaded, accept is high exactly when all 48 destination bits equal one of the 16 entries.
- R6: load_done pulses for one cycle right after the edge that samples the 192nd setup byte. From that edge on, the table counts as loaded.
- R7: Table matches are suppressed until a setup frame has completed. The start of a setup frame makes the table unloaded again. A setup frame cut short by a new frame start leaves it unloaded.
- R8: When accept_bcast is high, an all-ones destination is accepted whatever the table holds.
- R9: When promisc is high at the sixth destination byte, the frame is accepted, even before any table load.
- R10: Bytes after the sixth destination byte, bytes outside a frame, and frames shorter than six bytes produce no verdict. A new frame start restarts destination capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte strobe |
| in_first | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Stream byte |
| desc_setup | input | 1 | Setup flag from the control word, sampled with the first byte |
| desc_len | input | 11 | Frame length from the control word, sampled with the first byte |
| promisc | input | 1 | Accept every frame |
| accept_bcast | input | 1 | Accept the all-ones destination |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Verdict: high means the frame is kept |
| load_done | output | 1 | One-cycle pulse when a setup frame completes |

## Verification
A wrong byte position in the parser, such as keeping the duplicate pair or shifting the byte slot, corrupts stored entries without showing anything at once. It appears on the first verdict for a frame addressed to one of those entries, as a reject where an accept is expected. To expose that, the bench corrupts the duplicate copies in the setup frame. A wrong destination-byte counter or a wrong state transition shows within the same frame: verdict_vld is missing, arrives a byte early, or repeats on trailing bytes. A mishandled loaded flag shows on the first frame after an aborted or mis-sized setup frame.

// File: rtl/dpf_pkg.sv
`timescale 1ns/1ps
package dpf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DEST,
        ST_SKIP
    } dpf_state_e;
endpackage

// File: rtl/dpf_ctrl.sv
`timescale 1ns/1ps
module dpf_ctrl
    import dpf_pkg::*;
#(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6,
    parameter int LEN_W      = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_vld,
    input  logic                              in_first,
    input  logic                              desc_setup,
    input  logic [LEN_W-1:0]                  desc_len,
    output logic                              wr_en,
    output logic [$clog2(N_ENTRY)-1:0]        wr_ent,
    output logic [$clog2(ADDR_BYTES)-1:0]     wr_slot,
    output logic                              dst_we,
    output logic [$clog2(ADDR_BYTES)-1:0]     dst_slot,
    output logic                              dst_last,
    output logic                              tbl_ok,
    output logic                              load_done
);
    localparam int ENTRY_BYTES = 2 * ADDR_BYTES;
    localparam int SETUP_BYTES = N_ENTRY * ENTRY_BYTES;
    localparam int ENT_W       = $clog2(N_ENTRY);
    localparam int POS_W       = $clog2(ENTRY_BYTES);
    localparam int SLOT_W      = $clog2(ADDR_BYTES);

    dpf_state_e state, nxt;

    logic [POS_W-1:0]  pos, cur_pos;
    logic [ENT_W-1:0]  ent, cur_ent;
    logic [SLOT_W-1:0] dcnt, cur_dcnt;
    logic start, mid, is_setup, load_byte, dest_byte, last_load, pos_wrap;

    // Byte classification and table/destination strobes
    always_comb begin
        start     = in_vld & in_first;
        mid       = in_vld & ~in_first;
        is_setup  = desc_setup & (desc_len == LEN_W'(SETUP_BYTES));
        cur_pos   = start ? '0 : pos;
        cur_ent   = start ? '0 : ent;
        cur_dcnt  = start ? '0 : dcnt;
        load_byte = (start & is_setup) | (mid & (state == ST_LOAD));
        dest_byte = (start & ~desc_setup) | (mid & (state == ST_DEST));
        pos_wrap  = (cur_pos == POS_W'(ENTRY_BYTES - 1));
        last_load = load_byte & pos_wrap & (cur_ent == ENT_W'(N_ENTRY - 1));
        // positions 0,1 of every 4-byte group carry data, 2,3 repeat it
        wr_en     = load_byte & ~cur_pos[1];
        wr_ent    = cur_ent;
        wr_slot   = SLOT_W'(((cur_pos >> 2) << 1) | POS_W'(cur_pos[0]));
        dst_we    = dest_byte;
        dst_slot  = cur_dcnt;
        dst_last  = dest_byte & (cur_dcnt == SLOT_W'(ADDR_BYTES - 1));
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: ;
            ST_SKIP: ;
            ST_LOAD: if (last_load) nxt = ST_IDLE;
            ST_DEST: if (dst_last)  nxt = ST_IDLE;
        endcase
        if (start) begin
            if (is_setup)        nxt = ST_LOAD;
            else if (desc_setup) nxt = ST_SKIP;
            else                 nxt = ST_DEST;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Registered outputs and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos       <= '0;
            ent       <= '0;
            dcnt      <= '0;
            tbl_ok    <= 1'b0;
            load_done <= 1'b0;
        end else begin
            load_done <= last_load;
            if (load_byte) begin
                if (pos_wrap) begin
                    pos <= '0;
                    ent <= cur_ent + 1'b1;
                end else begin
                    pos <= cur_pos + 1'b1;
                    ent <= cur_ent;
                end
            end
            if (dest_byte)
                dcnt <= cur_dcnt + 1'b1;
            if (start & is_setup)
                tbl_ok <= 1'b0;
            if (last_load)
                tbl_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/dpf_table.sv
`timescale 1ns/1ps
module dpf_table
    import dpf_pkg::*;
#(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [$clog2(N_ENTRY)-1:0]                wr_ent,
    input  logic [$clog2(ADDR_BYTES)-1:0]             wr_slot,
    input  logic [BYTE_W-1:0]                         wr_data,
    output logic [N_ENTRY-1:0][ADDR_BYTES*BYTE_W-1:0] entries
);
    localparam int ENT_W  = $clog2(N_ENTRY);
    localparam int SLOT_W = $clog2(ADDR_BYTES);

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
        for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
            always_ff @(posedge clk) begin
                if (!rst_n)
                    entries[e][b*BYTE_W +: BYTE_W] <= '0;
                else if (wr_en && wr_ent == ENT_W'(e) && wr_slot == SLOT_W'(b))
                    entries[e][b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dpf_match.sv
`timescale 1ns/1ps
module dpf_match
    import dpf_pkg::*;
#(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      dst_we,
    input  logic [$clog2(ADDR_BYTES)-1:0]             dst_slot,
    input  logic                                      dst_last,
    input  logic [BYTE_W-1:0]                         in_byte,
    input  logic [N_ENTRY-1:0][ADDR_BYTES*BYTE_W-1:0] entries,
    input  logic                                      tbl_ok,
    input  logic                                      promisc,
    input  logic                                      accept_bcast,
    output logic                                      verdict_vld,
    output logic                                      accept
);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int SLOT_W = $clog2(ADDR_BYTES);

    logic [BYTE_W-1:0] dst_q [ADDR_BYTES-1];
    logic [ADDR_W-1:0] cand;
    logic [N_ENTRY-1:0] hit;

    // The last byte is compared straight from the stream
    for (genvar b = 0; b < ADDR_BYTES - 1; b++) begin : g_dst
        always_ff @(posedge clk) begin
            if (!rst_n)
                dst_q[b] <= '0;
            else if (dst_we && dst_slot == SLOT_W'(b))
                dst_q[b] <= in_byte;
        end
        assign cand[b*BYTE_W +: BYTE_W] = dst_q[b];
    end
    assign cand[ADDR_W-1 -: BYTE_W] = in_byte;

    for (genvar e = 0; e < N_ENTRY; e++) begin : g_cmp
        assign hit[e] = (entries[e] == cand);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_vld <= 1'b0;
            accept      <= 1'b0;
        end else begin
            verdict_vld <= dst_last;
            accept      <= dst_last & (promisc | (accept_bcast & (&cand)) | (tbl_ok & (|hit)));
        end
    end
endmodule

// File: rtl/dst_perfect_filter.sv
`timescale 1ns/1ps
module dst_perfect_filter
    import dpf_pkg::*;
#(
    parameter int N_ENTRY    = 16,
    parameter int ADDR_BYTES = 6,
    parameter int LEN_W      = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_first,
    input  logic [7:0]        in_byte,
    input  logic              desc_setup,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              promisc,
    input  logic              accept_bcast,
    output logic              verdict_vld,
    output logic              accept,
    output logic              load_done
);
    localparam int ENT_W  = $clog2(N_ENTRY);
    localparam int SLOT_W = $clog2(ADDR_BYTES);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;

    logic              wr_en;
    logic [ENT_W-1:0]  wr_ent;
    logic [SLOT_W-1:0] wr_slot;
    logic              dst_we;
    logic [SLOT_W-1:0] dst_slot;
    logic              dst_last;
    logic              tbl_ok;
    logic [N_ENTRY-1:0][ADDR_W-1:0] entries;

    dpf_ctrl #(.N_ENTRY(N_ENTRY), .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
        .desc_setup(desc_setup), .desc_len(desc_len),
        .wr_en(wr_en), .wr_ent(wr_ent), .wr_slot(wr_slot),
        .dst_we(dst_we), .dst_slot(dst_slot), .dst_last(dst_last),
        .tbl_ok(tbl_ok), .load_done(load_done)
    );

    dpf_table #(.N_ENTRY(N_ENTRY), .ADDR_BYTES(ADDR_BYTES)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ent(wr_ent),
        .wr_slot(wr_slot), .wr_data(in_byte), .entries(entries)
    );

    dpf_match #(.N_ENTRY(N_ENTRY), .ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk(clk), .rst_n(rst_n), .dst_we(dst_we), .dst_slot(dst_slot),
        .dst_last(dst_last), .in_byte(in_byte), .entries(entries),
        .tbl_ok(tbl_ok), .promisc(promisc), .accept_bcast(accept_bcast),
        .verdict_vld(verdict_vld), .accept(accept)
    );
endmodule

// File: rtl/dpf_checker.sv
`timescale 1ns/1ps
module dpf_checker (
    input logic clk,
    input logic rst_n,
    input logic in_vld,
    input logic in_first,
    input logic promisc,
    input logic accept_bcast,
    input logic verdict_vld,
    input logic accept,
    input logic load_done,
    input logic tbl_ok
);
    AST_VERDICT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |=> !verdict_vld); // R4
    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_vld |-> !accept); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done); // R6
    AST_DONE_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> ($past(in_vld) && !$past(in_first) && tbl_ok)); // R6
    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && $past(promisc)) |-> accept); // R9
    AST_UNLOADED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_vld && !$past(tbl_ok) && !$past(promisc) && !$past(accept_bcast)) |-> !accept); // R7
    AST_VERDICT_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |-> $past(in_vld)); // R10
endmodule

bind dst_perfect_filter dpf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
    .promisc(promisc), .accept_bcast(accept_bcast), .verdict_vld(verdict_vld),
    .accept(accept), .load_done(load_done), .tbl_ok(tbl_ok)
);

// File: tb/sim_dst_perfect_filter.sv
`timescale 1ns/1ps
module sim_dst_perfect_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_first = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        desc_setup = 1'b0;
    logic [10:0] desc_len = 11'd0;
    logic        promisc = 1'b0;
    logic        accept_bcast = 1'b0;
    logic        verdict_vld, accept, load_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dst_perfect_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
        .in_byte(in_byte), .desc_setup(desc_setup), .desc_len(desc_len),
        .promisc(promisc), .accept_bcast(accept_bcast),
        .verdict_vld(verdict_vld), .accept(accept), .load_done(load_done)
    );

    // {promisc, accept_bcast, destination (first wire byte at MSB), expected accept}
    localparam int NV = 12;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0, 1'b0, 48'h0200A55A30C0, 1'b1},  // R5 R3 entry 0
        {1'b0, 1'b0, 48'h02FFA55A3FCF, 1'b1},  // R5 R3 entry 15
        {1'b0, 1'b0, 48'h0277A55A37C7, 1'b1},  // R5 R3 entry 7
        {1'b0, 1'b0, 48'h0277A55A37C6, 1'b0},  // R5 last bit differs
        {1'b0, 1'b0, 48'h0377A55A37C7, 1'b0},  // R5 first byte differs
        {1'b0, 1'b0, 48'hFFFFFFFFFFFF, 1'b0},  // R8 broadcast, option off
        {1'b0, 1'b1, 48'hFFFFFFFFFFFF, 1'b1},  // R8 broadcast, option on
        {1'b1, 1'b0, 48'h123456789ABC, 1'b1},  // R9 promiscuous
        {1'b0, 1'b0, 48'h000000000000, 1'b0},  // R5 zero address
        {1'b0, 1'b1, 48'h0233A55A33C3, 1'b1},  // R8 option keeps table hits
        {1'b0, 1'b1, 48'hFFFFFFFFFFFE, 1'b0},  // R8 near-broadcast
        {1'b0, 1'b0, 48'hFDCC5AA5CC3C, 1'b0}   // R3 duplicate copy of entry 3
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ent_byte(input int i, input int j);
        case (j)
            0: return 8'h02;
            1: return 8'(i * 17);
            2: return 8'hA5;
            3: return 8'h5A;
            4: return 8'(8'h30 + i);
            default: return 8'hC0 ^ 8'(i);
        endcase
    endfunction

    task automatic put(input bit first, input logic [7:0] b, input bit setup, input logic [10:0] len);
        @(negedge clk);
        in_vld = 1'b1; in_first = first; in_byte = b;
        desc_setup = setup; desc_len = len;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0; in_first = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    // Sends nbytes of a setup-flagged frame; duplicate pairs are inverted
    task automatic send_setup(input int nbytes, input logic [10:0] len, input bit use_fill,
                              input logic [7:0] fill, input bit exp_done);
        for (int k = 0; k < nbytes; k++) begin
            int p, j;
            logic [7:0] b;
            p = k % 12;
            j = (p / 4) * 2 + (p % 2);
            b = ent_byte(k / 12, j);
            if ((p % 4) >= 2) b = ~b;
            if (use_fill) b = fill;
            put(k == 0, b, 1'b1, len);
            if (k == 190) check("R6 no early load_done", load_done, 0);
            if (k == 191) check("R6/R2 load_done after last byte", load_done, exp_done);
            if (k == 191) check("R2 no verdict in setup frame", verdict_vld, 0);
        end
        idle(1);
        check("R6 load_done one cycle", load_done, 0);
    endtask

    task automatic send_dest(input logic [47:0] a, input bit pm, input bit bc,
                             input bit exp, input string req);
        promisc = pm; accept_bcast = bc;
        for (int k = 0; k < 6; k++) begin
            put(k == 0, a[47 - 8*k -: 8], 1'b0, 11'd192);
            if (k == 4) check("R4 no verdict before sixth byte", verdict_vld, 0);
        end
        check({req, " verdict_vld"}, verdict_vld, 1);
        check({req, " accept"}, accept, exp);
        idle(1);
        check("R4 verdict one cycle", verdict_vld, 0);
        promisc = 1'b0; accept_bcast = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset verdict_vld", verdict_vld, 0);
        check("R1 reset accept", accept, 0);
        check("R1 reset load_done", load_done, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1 R7: zero entries must not match before a load
        send_dest(48'h0, 1'b0, 1'b0, 1'b0, "R1 R7 unloaded zero");
        send_dest(48'h0200A55A30C0, 1'b1, 1'b0, 1'b1, "R9 promisc before load");

        send_setup(192, 11'd192, 1'b0, 8'h00, 1'b1);

        for (int v = 0; v < NV; v++) begin
            logic [50:0] w;
            w = VEC[v];
            send_dest(w[48:1], w[50], w[49], w[0], $sformatf("R5 vector %0d", v));
        end

        // R2: setup flag with wrong length leaves table alone
        send_setup(192, 11'd191, 1'b1, 8'hEE, 1'b0);
        send_dest(48'h0200A55A30C0, 1'b0, 1'b0, 1'b1, "R2 table kept");
        send_dest(48'hEEEEEEEEEEEE, 1'b0, 1'b0, 1'b0, "R2 fill not stored");

        // R10: short frame, then restart, then trailing bytes
        for (int k = 0; k < 3; k++) put(k == 0, 8'h02, 1'b0, 11'd64);
        check("R10 short frame no verdict", verdict_vld, 0);
        send_dest(48'h0255A55A35C5, 1'b0, 1'b0, 1'b1, "R10 restart entry 5");
        for (int k = 0; k < 4; k++) begin
            put(1'b0, 8'h02, 1'b0, 11'd64);
            check("R10 trailing byte no verdict", verdict_vld, 0);
        end
        idle(2);
        for (int k = 0; k < 6; k++) put(1'b0, 8'hFF, 1'b0, 11'd64);
        check("R10 bytes outside frame no verdict", verdict_vld, 0);
        idle(1);

        // R7: aborted setup leaves table unloaded, full reload restores it
        send_setup(100, 11'd192, 1'b0, 8'h00, 1'b0);
        send_dest(48'h0200A55A30C0, 1'b0, 1'b0, 1'b0, "R7 aborted load rejects");
        send_setup(192, 11'd192, 1'b0, 8'h00, 1'b1);
        send_dest(48'h0200A55A30C0, 1'b0, 1'b0, 1'b1, "R7 reload accepts");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule